// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a record of which reset events a chip has gone through since software last looked. Three causes are tracked: power-on reset, a reset driven in from the external reset pin, and a reset raised by the low-voltage detector. Each cause owns one sticky flag. Hardware raises a flag when a one-cycle event pulse for that cause arrives. The flag stays raised until software writes a zero to its bit.

The flags sit in a 32-bit status word. Software reads the word directly from `status_o`, and clears flags through a single write strobe with a data word. Writing a one to a flag bit does nothing, so a read-modify-write never disturbs a flag. Only the power-on reset input `rst_ni` initialises the register. At that point the power-on flag comes up set and the other two come up clear. A reset caused by the external pin or the detector reaches the block only as an event pulse, so the record survives those resets. The event pulses must already be synchronous to `clk_i`.

Top module: `rst_cause_status`

## Requirements
- R1: While `rst_ni` is low and after it is released, `status_o` equals 32'h0000_0010: the power-on flag (bit 4) is set and the external-pin flag (bit 3) and low-voltage flag (bit 2) are clear.
- R2: A cycle with `por_evt_i` high sets bit 4 of `status_o` from the following cycle.
- R3: A cycle with `ext_evt_i` high sets bit 3 of `status_o` from the following cycle.
- R4: A cycle with `lvd_evt_i` high sets bit 2 of `status_o` from the following cycle.
- R5: A cycle with `wr_en_i` high and bit 4, 3 or 2 of `wr_data_i` low clears the matching flag from the following cycle, provided no event for that flag arrives in the same cycle.
- R6: A write with a one in a flag's bit position leaves that flag unchanged, whether it was set or clear.
- R7: Bits 31:5 and 1:0 of `status_o` always read 0.
- R8: When an event and a clearing write hit the same flag in the same cycle, the flag is set afterwards.
- R9: A flag holds its value while no event and no clearing write for it occurs, and an event for one cause leaves the other flags unchanged.
- R10: `wr_data_i` has no effect while `wr_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| por_evt_i | input | 1 | Power-on reset event pulse, synchronous |
| ext_evt_i | input | 1 | External pin reset event pulse, synchronous |
| lvd_evt_i | input | 1 | Low-voltage detector reset event pulse, synchronous |
| wr_en_i | input | 1 | Write strobe for the status word |
| wr_data_i | input | 32 | Write data; a zero in a flag bit clears that flag |
| status_o | output | 32 | Status word holding the three flags |

## Verification
The properties assume that the event inputs and the write strobe are clean levels sampled at the rising clock edge. They also assume that `rst_ni` is the only path that initialises the flags, so any change seen outside reset must come from an event or a write. The bench changes every input on the falling edge and holds it for a full clock period, so each event or write is seen at exactly one rising edge. It pulses `rst_ni` only between scenarios, with the inputs idle.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int DATA_W    = 32;
  localparam int NUM_CAUSE = 3;
  // flag index i lives at status bit FLAG_LSB + i; software decodes these positions
  localparam int FLAG_LSB  = 2;
  localparam int IDX_LVD   = 0;
  localparam int IDX_EXT   = 1;
  localparam int IDX_POR   = 2;
  localparam logic [NUM_CAUSE-1:0] FLAG_RST = 3'b100;
endpackage

// File: rtl/rcs_flag.sv
module rcs_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= RST_VAL;
    else if (set_i) flag_o <= 1'b1;   // set beats clear
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/rcs_wr_decode.sv
module rcs_wr_decode #(
  parameter int DATA_W    = 32,
  parameter int NUM_CAUSE = 3,
  parameter int FLAG_LSB  = 2
) (
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic                 wr_en_i,
  output logic [NUM_CAUSE-1:0] clr_o
);
  localparam int FLAG_MSB = FLAG_LSB + NUM_CAUSE - 1;

  for (genvar i = 0; i < NUM_CAUSE; i++) begin : g_clr
    assign clr_o[i] = wr_en_i & ~wr_data_i[FLAG_LSB+i];
  end

  logic unused_data;
  assign unused_data = ^{wr_data_i[DATA_W-1:FLAG_MSB+1], wr_data_i[FLAG_LSB-1:0]};
endmodule

// File: rtl/rcs_word_pack.sv
module rcs_word_pack #(
  parameter int DATA_W    = 32,
  parameter int NUM_CAUSE = 3,
  parameter int FLAG_LSB  = 2
) (
  input  logic [NUM_CAUSE-1:0] flags_i,
  output logic [DATA_W-1:0]    word_o
);
  always_comb begin
    word_o = '0;
    word_o[FLAG_LSB +: NUM_CAUSE] = flags_i;
  end
endmodule

// File: rtl/rst_cause_status.sv
module rst_cause_status
  import rcs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_evt_i,
  input  logic              ext_evt_i,
  input  logic              lvd_evt_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] status_o
);
  logic [NUM_CAUSE-1:0] evt;
  logic [NUM_CAUSE-1:0] clr;
  logic [NUM_CAUSE-1:0] flags;

  always_comb begin
    evt          = '0;
    evt[IDX_LVD] = lvd_evt_i;
    evt[IDX_EXT] = ext_evt_i;
    evt[IDX_POR] = por_evt_i;
  end

  rcs_wr_decode #(
    .DATA_W(DATA_W), .NUM_CAUSE(NUM_CAUSE), .FLAG_LSB(FLAG_LSB)
  ) u_dec (
    .wr_data_i(wr_data_i),
    .wr_en_i  (wr_en_i),
    .clr_o    (clr)
  );

  for (genvar i = 0; i < NUM_CAUSE; i++) begin : g_flag
    rcs_flag #(.RST_VAL(FLAG_RST[i])) u_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (evt[i]),
      .clr_i (clr[i]),
      .flag_o(flags[i])
    );
  end

  rcs_word_pack #(
    .DATA_W(DATA_W), .NUM_CAUSE(NUM_CAUSE), .FLAG_LSB(FLAG_LSB)
  ) u_pack (
    .flags_i(flags),
    .word_o (status_o)
  );
endmodule

// File: rtl/rcs_checker.sv
module rcs_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              por_evt_i,
  input logic              ext_evt_i,
  input logic              lvd_evt_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] status_o
);
  localparam logic [DATA_W-1:0] FLAG_MASK = 32'h0000_001C;

  logic [2:0] ev;
  assign ev = {por_evt_i, ext_evt_i, lvd_evt_i};

  p_set_por_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_evt_i |=> status_o[4]);
  p_set_ext_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_evt_i |=> status_o[3]);
  p_set_lvd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvd_evt_i |=> status_o[2]);
  p_reserved_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o & ~FLAG_MASK) == '0);

  for (genvar i = 0; i < 3; i++) begin : g_bit
    p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !wr_data_i[i+2] && !ev[i]) |=> !status_o[i+2]);
    p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ev[i] && (!wr_en_i || wr_data_i[i+2])) |=> $stable(status_o[i+2]));
    p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev[i] && wr_en_i && !wr_data_i[i+2]) |=> status_o[i+2]);
  end
endmodule

bind rst_cause_status rcs_checker #(.DATA_W(32)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .por_evt_i(por_evt_i),
  .ext_evt_i(ext_evt_i),
  .lvd_evt_i(lvd_evt_i),
  .wr_en_i  (wr_en_i),
  .wr_data_i(wr_data_i),
  .status_o (status_o)
);

// File: tb/tb_rst_cause_status.sv
`timescale 1ns/1ps
module tb_rst_cause_status;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        por_evt_i = 1'b0, ext_evt_i = 1'b0, lvd_evt_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] status_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  rst_cause_status dut (.*);

  task automatic chk(input string req, input logic [31:0] exp);
    n_chk++;
    if (status_o !== exp) begin
      n_fail++;
      $display("FAIL %s: status_o=%h expected=%h", req, status_o, exp);
    end
    n_chk++;
    if ((status_o & ~32'h1C) !== '0) begin
      n_fail++;
      $display("FAIL R7: status_o=%h reserved bits nonzero, expected=%h", status_o, exp & 32'h1C);
    end
  endtask

  // apply inputs on a falling edge for exactly one rising edge
  task automatic cyc(input logic p, input logic e, input logic l,
                     input logic w, input logic [31:0] d);
    por_evt_i = p; ext_evt_i = e; lvd_evt_i = l; wr_en_i = w; wr_data_i = d;
    @(negedge clk_i);
    por_evt_i = 0; ext_evt_i = 0; lvd_evt_i = 0; wr_en_i = 0; wr_data_i = '0;
  endtask

  task automatic do_por();
    rst_ni = 1'b0;
    #3;
    chk("R1 during reset", 32'h10);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after reset", 32'h10);
  endtask

  task automatic t_write_ones();
    cyc(0, 0, 0, 1, 32'hFFFF_FFFF);
    chk("R6 ones keep set flag", 32'h10);
    cyc(0, 0, 0, 1, 32'hFFFF_FFEF);
    chk("R5 clear por flag", 32'h00);
    cyc(0, 0, 0, 1, 32'hFFFF_FFFF);
    chk("R6 ones do not set", 32'h00);
  endtask

  task automatic t_events();
    cyc(0, 1, 0, 0, '0);
    chk("R3 ext event", 32'h08);
    cyc(0, 0, 1, 0, '0);
    chk("R4 lvd event, R9 ext kept", 32'h0C);
    cyc(1, 0, 0, 0, '0);
    chk("R2 por event", 32'h1C);
    repeat (5) @(negedge clk_i);
    chk("R9 sticky", 32'h1C);
  endtask

  task automatic t_selective();
    cyc(0, 0, 0, 1, 32'hFFFF_FFF7);
    chk("R5 clear ext only", 32'h14);
    cyc(0, 0, 0, 0, 32'h0);
    chk("R10 no strobe", 32'h14);
    wr_data_i = 32'h0;
    repeat (3) @(negedge clk_i);
    chk("R10 data without strobe", 32'h14);
    cyc(0, 0, 0, 1, 32'hFFFF_FFFB);
    chk("R5 clear lvd only", 32'h10);
  endtask

  task automatic t_set_wins();
    cyc(0, 1, 0, 1, 32'h0);
    chk("R8 ext set beats clear", 32'h08);
    cyc(1, 0, 1, 1, 32'h0);
    chk("R8 por,lvd set beat clear", 32'h14);
    cyc(0, 1, 0, 0, '0);
    chk("R9 ext event leaves others", 32'h1C);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    do_por();
    t_write_ones();
    t_events();
    t_selective();
    t_set_wins();
    do_por();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule